// File: doc/BRIEF.md
# Dword Output Buffer with Hysteresis Fill Flag

This block sits at the end of a video capture path. An upstream scaler or formatter writes 32-bit Dwords into it, and it sends them out on a physical port that is either 8 or 16 bits wide. It presents one byte or halfword per clock and marks each valid beat with a qualifier strobe. It drains on its own whenever it holds data. Reading and writing share one clock.

Besides the data stream it drives three status flags. The almost-empty flag is combinational and uses a programmable threshold. The fill flag rises at a programmable almost-full level and falls only when the store drops under the almost-empty threshold, so it has hysteresis. The overflow flag is sticky and records writes that were dropped. A general-purpose status pin carries one of these flags, or constant 0, depending on a select input.

Top module: `dword_out_fifo`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the store: afterwards `out_strb`, `fill_flag` and `ovf_flag` are 0 and `ae_flag` is 1.
- R2: The store holds up to 32 Dwords. A write (`wr_en` high) is accepted while fewer than 32 are held, and Dwords leave in the order they were written.
- R3: With `wide_mode` = 0 each Dword is sent as four beats on `out_data[7:0]`. Beat k carries bits [8k+7:8k], so the least significant byte goes first. `out_data[15:8]` is 0 in this mode.
- R4: With `wide_mode` = 1 each Dword is sent as two beats on `out_data[15:0]`: bits [15:0] first, then bits [31:16].
- R5: With `swap_order` = 1 the beat order within a Dword is reversed: the most significant byte or halfword goes first.
- R6: `out_strb` is 1 exactly on the cycles where at least one Dword is held. There is one beat per strobed cycle, and the next Dword starts only after the last beat of the current one.
- R7: `ae_flag` is 1 when the number of stored Dwords is below 16, 8, 4 or 1, for `ae_sel` = 0, 1, 2, 3 respectively.
- R8: `fill_flag` rises in the cycle the stored count reaches 16, 24, 28 or 32, for `af_sel` = 0, 1, 2, 3 respectively.
- R9: Once set, `fill_flag` stays 1 until the stored count falls below the `ae_sel` threshold of R7.
- R10: A write that arrives while 32 Dwords are held is dropped and sets `ovf_flag`. The flag holds its value while `ovf_clr` is low.
- R11: `ovf_clr` clears `ovf_flag` at the next edge, unless a write is dropped in the same cycle; a dropped write takes priority.
- R12: `gp_stat` follows `gp_sel`: 0 gives constant 0, 1 gives `fill_flag`, 2 gives `ovf_flag`, 3 gives `ae_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the write and the read side |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request for one Dword |
| wr_data | input | 32 | Dword to store |
| wide_mode | input | 1 | 0: 8-bit port, 1: 16-bit port |
| swap_order | input | 1 | Reverses the beat order within a Dword |
| ae_sel | input | 2 | Almost-empty threshold select |
| af_sel | input | 2 | Almost-full threshold select |
| gp_sel | input | 2 | Status pin source select |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_data | output | 16 | Output byte or halfword |
| out_strb | output | 1 | High on cycles carrying a valid beat |
| ae_flag | output | 1 | Almost-empty flag |
| fill_flag | output | 1 | Fill flag with hysteresis |
| ovf_flag | output | 1 | Sticky overflow flag |
| gp_stat | output | 1 | Selected status flag |

## Verification
The following are checked on every cycle: the count stays within the store, the fill flag is set at or above the almost-full level and clear below the almost-empty level, the overflow flag is sticky and responds to a clear, a full write sets overflow, an empty store reports almost-empty, the status pin is low when select 0 is chosen, and the upper byte is zero in 8-bit mode. Other behaviour depends on the history of the data and can only be shown by the bench's scenarios. This covers the beat order in both widths with and without swap, Dword order across back-to-back writes, the fill flag holding through the gap between the two thresholds, and every combination of the threshold selects. The bench compares each of these against an independent cycle model.

// File: rtl/dwf_pkg.sv
package dwf_pkg;

    // Almost-empty limit: flag is set while the count is below this value.
    function automatic int ae_limit(input logic [1:0] sel, input int depth);
        if (sel == 2'd3) return 1;
        return (depth / 2) >> sel;
    endfunction

    // Almost-full limit: fill flag rises once the count reaches this value.
    function automatic int af_limit(input logic [1:0] sel, input int depth);
        if (sel == 2'd3) return depth;
        return depth - ((depth / 2) >> sel);
    endfunction

    typedef enum logic [1:0] {
        GP_ZERO = 2'd0,
        GP_FILL = 2'd1,
        GP_OVF  = 2'd2,
        GP_AE   = 2'd3
    } gp_src_e;

endpackage

// File: rtl/dwf_store.sv
module dwf_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pop,
    output logic          accept,
    output logic          drop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] level,
    output logic [LW-1:0] level_nxt
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
    } store_st_t;

    store_st_t     s_d, s_q;
    logic [DW-1:0] mem [DEPTH];
    logic          full;

    always_comb begin
        s_d    = s_q;
        full   = (s_q.lvl == LW'(DEPTH));
        accept = wr_en && !full;
        drop   = wr_en && full;
        if (accept) begin
            s_d.wp = (s_q.wp == AW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (pop) begin
            s_d.rp = (s_q.rp == AW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        end
        s_d.lvl = s_q.lvl + LW'(accept) - LW'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (accept) mem[s_q.wp] <= wr_data;
    end

    assign head      = mem[s_q.rp];
    assign level     = s_q.lvl;
    assign level_nxt = s_d.lvl;

endmodule

// File: rtl/dwf_serial.sv
module dwf_serial #(
    parameter int DW  = 32,
    parameter int OW  = 16,
    parameter int NB  = DW / 8,
    parameter int NH  = DW / 16,
    parameter int BTW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          avail,
    input  logic [DW-1:0] word,
    input  logic          wide_mode,
    input  logic          swap_order,
    output logic [OW-1:0] beat_data,
    output logic          beat_vld,
    output logic          pop
);

    typedef struct packed {
        logic [BTW-1:0] beat;
    } ser_st_t;

    ser_st_t s_d, s_q;
    logic    last;
    int      idx;

    always_comb begin
        s_d  = s_q;
        last = wide_mode ? (int'(s_q.beat) >= NH - 1) : (int'(s_q.beat) == NB - 1);
        pop  = avail && last;
        if (avail) begin
            s_d.beat = last ? '0 : s_q.beat + 1'b1;
        end
        beat_data = '0;
        if (wide_mode) begin
            idx = swap_order ? (NH - 1 - int'(s_q.beat % NH)) : int'(s_q.beat % NH);
            beat_data = word[idx*16 +: 16];
        end else begin
            idx = swap_order ? (NB - 1 - int'(s_q.beat)) : int'(s_q.beat);
            beat_data[7:0] = word[idx*8 +: 8];
        end
        beat_vld = avail;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

endmodule

// File: rtl/dwf_flags.sv
module dwf_flags #(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] level_nxt,
    input  logic [1:0]    ae_sel,
    input  logic [1:0]    af_sel,
    input  logic          drop,
    input  logic          ovf_clr,
    output logic          ae_flag,
    output logic          fill_flag,
    output logic          ovf_flag
);

    typedef struct packed {
        logic fill;
        logic ovf;
    } flg_st_t;

    flg_st_t f_d, f_q;
    int      ae_lim, af_lim;

    always_comb begin
        f_d    = f_q;
        ae_lim = dwf_pkg::ae_limit(ae_sel, DEPTH);
        af_lim = dwf_pkg::af_limit(af_sel, DEPTH);
        if (f_q.fill) begin
            if (int'(level_nxt) < ae_lim) f_d.fill = 1'b0;
        end else if (int'(level_nxt) >= af_lim) begin
            f_d.fill = 1'b1;
        end
        if (drop)         f_d.ovf = 1'b1;
        else if (ovf_clr) f_d.ovf = 1'b0;
        ae_flag = (int'(level) < ae_lim);
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assign fill_flag = f_q.fill;
    assign ovf_flag  = f_q.ovf;

endmodule

// File: rtl/dword_out_fifo.sv
module dword_out_fifo #(
    parameter int DW    = 32,
    parameter int OW    = 16,
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wide_mode,
    input  logic          swap_order,
    input  logic [1:0]    ae_sel,
    input  logic [1:0]    af_sel,
    input  logic [1:0]    gp_sel,
    input  logic          ovf_clr,
    output logic [OW-1:0] out_data,
    output logic          out_strb,
    output logic          ae_flag,
    output logic          fill_flag,
    output logic          ovf_flag,
    output logic          gp_stat
);

    logic          accept, drop, pop;
    logic [DW-1:0] head;
    logic [LW-1:0] level, level_nxt;

    dwf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
        .accept(accept), .drop(drop), .head(head),
        .level(level), .level_nxt(level_nxt)
    );

    dwf_serial #(.DW(DW), .OW(OW)) u_serial (
        .clk(clk), .rst(rst), .avail(level != '0), .word(head),
        .wide_mode(wide_mode), .swap_order(swap_order),
        .beat_data(out_data), .beat_vld(out_strb), .pop(pop)
    );

    dwf_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst(rst), .level(level), .level_nxt(level_nxt),
        .ae_sel(ae_sel), .af_sel(af_sel), .drop(drop), .ovf_clr(ovf_clr),
        .ae_flag(ae_flag), .fill_flag(fill_flag), .ovf_flag(ovf_flag)
    );

    always_comb begin
        unique case (dwf_pkg::gp_src_e'(gp_sel))
            dwf_pkg::GP_FILL: gp_stat = fill_flag;
            dwf_pkg::GP_OVF:  gp_stat = ovf_flag;
            dwf_pkg::GP_AE:   gp_stat = ae_flag;
            default:          gp_stat = 1'b0;
        endcase
    end

    logic unused_accept;
    assign unused_accept = accept;

endmodule

// File: rtl/dwf_checker.sv
module dwf_checker #(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          ovf_clr,
    input logic          wide_mode,
    input logic [1:0]    ae_sel,
    input logic [1:0]    af_sel,
    input logic [1:0]    gp_sel,
    input logic [15:0]   out_data,
    input logic          ae_flag,
    input logic          fill_flag,
    input logic          ovf_flag,
    input logic          gp_stat,
    input logic [LW-1:0] level
);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= DEPTH); // R2

    AST_HIGH_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !wide_mode |-> out_data[15:8] == 8'h00); // R3

    AST_EMPTY_IS_AE: assert property (@(posedge clk) disable iff (rst)
        level == '0 |-> ae_flag); // R7

    AST_FILL_AT_AF: assert property (@(posedge clk) disable iff (rst)
        $stable(af_sel) && int'(level) >= dwf_pkg::af_limit(af_sel, DEPTH) |-> fill_flag); // R8

    AST_FILL_CLR_BELOW_AE: assert property (@(posedge clk) disable iff (rst)
        $stable(ae_sel) && int'(level) < dwf_pkg::ae_limit(ae_sel, DEPTH) |-> !fill_flag); // R9

    AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
        wr_en && int'(level) == DEPTH |=> ovf_flag); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_flag && !ovf_clr |=> ovf_flag); // R10

    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ovf_clr && !wr_en |=> !ovf_flag); // R11

    AST_GP_ZERO: assert property (@(posedge clk) disable iff (rst)
        gp_sel == 2'd0 |-> !gp_stat); // R12

endmodule

bind dword_out_fifo dwf_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ovf_clr(ovf_clr),
    .wide_mode(wide_mode), .ae_sel(ae_sel), .af_sel(af_sel), .gp_sel(gp_sel),
    .out_data(out_data), .ae_flag(ae_flag), .fill_flag(fill_flag),
    .ovf_flag(ovf_flag), .gp_stat(gp_stat), .level(level)
);

// File: tb/sim_dword_out_fifo.sv
`timescale 1ns/1ps
module sim_dword_out_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wide_mode = 1'b0;
    logic        swap_order = 1'b0;
    logic [1:0]  ae_sel = 2'd0;
    logic [1:0]  af_sel = 2'd0;
    logic [1:0]  gp_sel = 2'd0;
    logic        ovf_clr = 1'b0;
    logic [15:0] out_data;
    logic        out_strb, ae_flag, fill_flag, ovf_flag, gp_stat;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    dword_out_fifo u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wide_mode(wide_mode), .swap_order(swap_order),
        .ae_sel(ae_sel), .af_sel(af_sel), .gp_sel(gp_sel), .ovf_clr(ovf_clr),
        .out_data(out_data), .out_strb(out_strb), .ae_flag(ae_flag),
        .fill_flag(fill_flag), .ovf_flag(ovf_flag), .gp_stat(gp_stat)
    );

    // Independent cycle model built from the requirements
    logic [31:0] mq [64];
    int mh = 0, mc = 0, mb = 0;
    bit mfill = 0, movf = 0;

    function automatic int ae_th(input logic [1:0] s);
        case (s) 2'd0: return 16; 2'd1: return 8; 2'd2: return 4; default: return 1; endcase
    endfunction
    function automatic int af_th(input logic [1:0] s);
        case (s) 2'd0: return 16; 2'd1: return 24; 2'd2: return 28; default: return 32; endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mh = 0; mc = 0; mb = 0; mfill = 0; movf = 0;
        end else begin
            int  nb;
            bit  last, pop, push, drop;
            nb   = wide_mode ? 2 : 4;
            last = (mb == nb - 1);
            pop  = (mc != 0) && last;
            push = wr_en && (mc != 32);
            drop = wr_en && (mc == 32);
            if (mc != 0) mb = last ? 0 : mb + 1;
            if (push) mq[(mh + mc) % 64] = wr_data;
            if (pop) mh = (mh + 1) % 64;
            mc = mc + int'(push) - int'(pop);
            if (mfill) begin
                if (mc < ae_th(ae_sel)) mfill = 0;
            end else if (mc >= af_th(af_sel)) begin
                mfill = 1;
            end
            if (drop) movf = 1;
            else if (ovf_clr) movf = 0;
        end
    end

    task automatic cmp(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic check_model();
        logic [31:0] w;
        int idx, ed;
        bit egp;
        cmp("R6", "out_strb", int'(out_strb), int'(mc != 0));
        if (mc != 0) begin
            w = mq[mh];
            if (wide_mode) begin
                idx = swap_order ? 1 - mb : mb;
                ed  = int'(w[idx*16 +: 16]);
                cmp("R2 R4 R5", "out_data", int'(out_data), ed);
            end else begin
                idx = swap_order ? 3 - mb : mb;
                ed  = int'(w[idx*8 +: 8]);
                cmp("R2 R3 R5", "out_data", int'(out_data), ed);
            end
        end
        cmp("R7", "ae_flag", int'(ae_flag), int'(mc < ae_th(ae_sel)));
        cmp("R8/R9", "fill_flag", int'(fill_flag), int'(mfill));
        cmp("R10/R11", "ovf_flag", int'(ovf_flag), int'(movf));
        case (gp_sel)
            2'd1: egp = mfill;
            2'd2: egp = movf;
            2'd3: egp = (mc < ae_th(ae_sel));
            default: egp = 0;
        endcase
        cmp("R12", "gp_stat", int'(gp_stat), int'(egp));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cyc++;
        check_model();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; ovf_clr = 1'b0;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        wr_en = 1'b1; wr_data = 32'hDEADBEEF;
        step();
        step();
        wr_en = 1'b0;
        do_reset();
        cmp("R1", "strb after reset", int'(out_strb), 0);
        cmp("R1", "ae after reset", int'(ae_flag), 1);
        cmp("R1", "fill after reset", int'(fill_flag), 0);
        cmp("R1", "ovf after reset", int'(ovf_flag), 0);
    endtask

    task automatic t_bytes(input bit swp);
        do_reset();
        wide_mode = 1'b0; swap_order = swp;
        wr_en = 1'b1; wr_data = 32'h44332211;
        step();
        wr_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            cmp(swp ? "R5" : "R3", "byte beat", int'(out_data), swp ? (8'h44 - 8'h11 * k) : (8'h11 * (k + 1)));
            cmp("R6", "strb during dword", int'(out_strb), 1);
            step();
        end
        cmp("R6", "strb after last byte", int'(out_strb), 0);
    endtask

    task automatic t_halves(input bit swp);
        int exp_seq [4];
        do_reset();
        wide_mode = 1'b1; swap_order = swp;
        if (swp) exp_seq = '{32'h4433, 32'h2211, 32'h8877, 32'h6655};
        else     exp_seq = '{32'h2211, 32'h4433, 32'h6655, 32'h8877};
        wr_en = 1'b1; wr_data = 32'h44332211;
        step();
        wr_data = 32'h88776655;
        for (int k = 0; k < 4; k++) begin
            cmp(swp ? "R5" : "R4", "half beat", int'(out_data), exp_seq[k]);
            step();
            wr_en = 1'b0;
        end
        cmp("R6", "strb after two dwords", int'(out_strb), 0);
    endtask

    task automatic t_hysteresis();
        do_reset();
        wide_mode = 1'b1; swap_order = 1'b0;
        af_sel = 2'd0; ae_sel = 2'd2; gp_sel = 2'd1;
        wr_en = 1'b1;
        while (mc < 16) begin
            wr_data = 32'h1000_0000 + cyc;
            step();
        end
        wr_en = 1'b0;
        cmp("R8", "fill at 16", int'(fill_flag), 1);
        while (mc >= 4) begin
            cmp("R9", "fill held above ae", int'(fill_flag), 1);
            step();
        end
        cmp("R9", "fill cleared below ae", int'(fill_flag), 0);
        cmp("R12", "gp shows fill", int'(gp_stat), 0);
        while (mc != 0) step();
    endtask

    task automatic t_overflow();
        do_reset();
        wide_mode = 1'b0; gp_sel = 2'd2; af_sel = 2'd3; ae_sel = 2'd0;
        wr_en = 1'b1;
        while (mc < 32) begin
            wr_data = 32'hA000_0000 + cyc;
            step();
        end
        cmp("R8", "fill at full", int'(fill_flag), 1);
        cmp("R10", "no ovf yet", int'(ovf_flag), 0);
        step();
        cmp("R10", "ovf after dropped write", int'(ovf_flag), 1);
        wr_en = 1'b0;
        step(); step();
        cmp("R10", "ovf sticky", int'(ovf_flag), 1);
        cmp("R12", "gp shows ovf", int'(gp_stat), 1);
        while (mc < 32) begin
            wr_en = 1'b1; wr_data = 32'hB000_0000 + cyc;
            step();
        end
        ovf_clr = 1'b1;
        step();
        cmp("R11", "drop beats clear", int'(ovf_flag), 1);
        wr_en = 1'b0;
        step();
        ovf_clr = 1'b0;
        cmp("R11", "ovf cleared", int'(ovf_flag), 0);
        while (mc != 0) step();
    endtask

    task automatic t_sweep();
        for (int a = 0; a < 4; a++) begin
            for (int f = 0; f < 4; f++) begin
                do_reset();
                ae_sel = 2'(a); af_sel = 2'(f); gp_sel = 2'((a + f) % 4);
                wide_mode = f[0]; swap_order = a[0];
                wr_en = 1'b1;
                for (int k = 0; k < 90; k++) begin
                    wr_data = {8'(a), 8'(f), 16'(k)} ^ 32'h5A5A_0000;
                    step();
                end
                wr_en = 1'b0;
                ovf_clr = 1'b1;
                step();
                ovf_clr = 1'b0;
                for (int k = 0; k < 140; k++) step();
                cmp("R6", "drained", int'(out_strb), 0);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        do_reset();
        cmp("R1", "ae at start", int'(ae_flag), 1);
        cmp("R1", "strb at start", int'(out_strb), 0);
        t_reset();
        t_bytes(1'b0);
        t_bytes(1'b1);
        t_halves(1'b0);
        t_halves(1'b1);
        t_hysteresis();
        t_overflow();
        t_sweep();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule